// File: doc/BRIEF.md
# Ping-Pong Receive DMA with Error Offset Capture

This block moves characters from a small serial receive queue into memory, alternating between two buffers, A and B. Software arms a buffer by giving it a base address and a length in characters. The engine then writes each queued character to the next address of the buffer it is filling. When that buffer is full, its active flag drops and filling moves on to the other buffer. If the other buffer is not armed, the characters wait in the queue.

Every queued character carries a parity-error bit and a frame-error bit. When a flagged character is moved to memory, the buffer it lands in keeps the position of that character as its error offset. Only the first bad character in a buffer is kept. A character that arrives while the queue is full is lost. The block then raises a one-cycle overrun pulse and a sticky overrun status at once. It also marks an offset in the buffer being filled. That offset lies one full queue depth past the position the lost character would have taken. The error marks are cleared by the DMA reset control, or by arming the buffer again once it has finished.

The write port has no back-pressure. After each write, the engine leaves the port idle for a set number of cycles. For this reason, a steady input of one character per clock fills the queue and overruns it.

Top module: `rxdma_pingpong`

## Requirements
- R1: After rst_n is low, both active flags, both error-valid flags, mem_we, ovf_irq and ovf_status are 0.
- R2: Each character is written once, in arrival order, to the address base plus its offset in the buffer being filled. With the default XFER_GAP of 1, no two writes occur in consecutive cycles. Input at one character per clock into an idle queue therefore loses its ninth character first.
- R3: A load pulse with a non-zero length sets that buffer's active flag. The flag clears after length characters have been written. Filling then continues into the other buffer if it is active, and buffer A is filled first after reset.
- R4: No write occurs unless a buffer is active. Characters received while no buffer is active stay queued, up to 4 of them, and are written in order once a buffer is loaded.
- R5: When a character with the parity-error bit or the frame-error bit set is written, its buffer's error-valid flag sets and its error offset takes that character's offset. The first such character only sets these; later errors in the same buffer leave them unchanged.
- R6: A character arriving while the queue holds 4 entries and no entry leaves that cycle is dropped. ovf_irq is high for one cycle after that edge, and ovf_status stays high until dma_reset.
- R7: On an overrun while a buffer is active and has no error yet, that buffer's error offset becomes the offset the lost character would have had, plus 4. On an overrun while no buffer is active, no error offset is recorded.
- R8: Loading a buffer whose active flag is clear clears its error-valid flag and sets its error offset to 0. A load while the buffer is active is ignored.
- R9: dma_reset clears both active flags, both error marks, ovf_status and the queue.
- R10: A load with a length of 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_reset | input | 1 | Synchronous clear of the DMA state, the error marks and the queue |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | DATA_W | Received character |
| rx_perr | input | 1 | Parity error for this character |
| rx_ferr | input | 1 | Frame error for this character |
| load_a | input | 1 | Arm buffer A |
| base_a | input | ADDR_W | Buffer A base address |
| len_a | input | LEN_W | Buffer A length in characters |
| load_b | input | 1 | Arm buffer B |
| base_b | input | ADDR_W | Buffer B base address |
| len_b | input | LEN_W | Buffer B length in characters |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| act_a | output | 1 | Buffer A is being filled or waiting to be filled |
| act_b | output | 1 | Buffer B is being filled or waiting to be filled |
| err_valid_a | output | 1 | Buffer A holds an error offset |
| err_valid_b | output | 1 | Buffer B holds an error offset |
| err_off_a | output | LEN_W | Buffer A error offset |
| err_off_b | output | LEN_W | Buffer B error offset |
| ovf_irq | output | 1 | One-cycle overrun pulse |
| ovf_status | output | 1 | Sticky overrun status |

## Verification
The hardest state to reach is an overrun that happens while a buffer is active. Only then does the shifted overrun offset get recorded. The stimulus reaches it by streaming one character per clock into a long, armed buffer, which outruns the write rate. The bench finds the first lost character from the write log and expects the recorded offset to be that character's offset plus 4. Error positions are swept over every offset of buffer lengths 1 to 4, in both buffers.

// File: rtl/rxdma_pingpong.sv
module rxdma_pingpong #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int XFER_GAP   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_reset,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              load_a,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [LEN_W-1:0]  len_a,
  input  logic              load_b,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [LEN_W-1:0]  len_b,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              act_a,
  output logic              act_b,
  output logic              err_valid_a,
  output logic              err_valid_b,
  output logic [LEN_W-1:0]  err_off_a,
  output logic [LEN_W-1:0]  err_off_b,
  output logic              ovf_irq,
  output logic              ovf_status
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int GAP_W = (XFER_GAP > 0) ? $clog2(XFER_GAP + 1) : 1;
  localparam int ENT_W = DATA_W + 2;

  logic [ENT_W-1:0]  fifo_q [FIFO_DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q, rd_nxt, wr_nxt;
  logic [CNT_W-1:0]  used_q;
  logic [GAP_W-1:0]  gap_q;

  logic [ADDR_W-1:0] base_q [2];
  logic [LEN_W-1:0]  len_q  [2];
  logic [LEN_W-1:0]  cnt_q  [2];
  logic [LEN_W-1:0]  eoff_q [2];
  logic [1:0]        act_q, ev_q;
  logic              cur_q;

  logic [1:0]        ld;
  logic [ADDR_W-1:0] ld_base [2];
  logic [LEN_W-1:0]  ld_len  [2];

  logic              we_q, irq_q, ovst_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              tgt, busy, full, empty, pop, push, ovf, head_bad, at_last;
  logic [ENT_W-1:0]  head;
  logic [LEN_W-1:0]  ovf_ofs;

  assign ld         = {load_b, load_a};
  assign ld_base[0] = base_a;
  assign ld_base[1] = base_b;
  assign ld_len[0]  = len_a;
  assign ld_len[1]  = len_b;

  assign tgt      = act_q[cur_q] ? cur_q : ~cur_q;
  assign busy     = act_q[tgt];
  assign full     = used_q == CNT_W'(FIFO_DEPTH);
  assign empty    = used_q == '0;
  assign pop      = !empty && busy && gap_q == '0;
  assign push     = rx_valid && (!full || pop);
  assign ovf      = rx_valid && full && !pop;
  assign head     = fifo_q[rd_q];
  assign head_bad = head[DATA_W] | head[DATA_W+1];
  assign at_last  = cnt_q[tgt] == len_q[tgt] - 1'b1;
  assign ovf_ofs  = cnt_q[tgt] + LEN_W'(2 * FIFO_DEPTH);
  assign rd_nxt   = (rd_q == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rd_q + 1'b1;
  assign wr_nxt   = (wr_q == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (push) fifo_q[wr_q] <= {rx_ferr, rx_perr, rx_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      used_q  <= '0;
      gap_q   <= '0;
      act_q   <= '0;
      ev_q    <= '0;
      cur_q   <= 1'b0;
      we_q    <= 1'b0;
      irq_q   <= 1'b0;
      ovst_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      for (int i = 0; i < 2; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        cnt_q[i]  <= '0;
        eoff_q[i] <= '0;
      end
    end else if (dma_reset) begin
      rd_q    <= '0;
      wr_q    <= '0;
      used_q  <= '0;
      gap_q   <= '0;
      act_q   <= '0;
      ev_q    <= '0;
      cur_q   <= 1'b0;
      we_q    <= 1'b0;
      irq_q   <= 1'b0;
      ovst_q  <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        cnt_q[i]  <= '0;
        eoff_q[i] <= '0;
      end
    end else begin
      we_q  <= pop;
      irq_q <= ovf;
      if (ovf) ovst_q <= 1'b1;

      if (pop) gap_q <= GAP_W'(XFER_GAP);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;

      if (push) wr_q <= wr_nxt;
      if (pop) rd_q <= rd_nxt;
      used_q <= used_q + CNT_W'(push) - CNT_W'(pop);

      for (int i = 0; i < 2; i++) begin
        if (!act_q[i] && ld[i] && ld_len[i] != '0) begin
          act_q[i]  <= 1'b1;
          base_q[i] <= ld_base[i];
          len_q[i]  <= ld_len[i];
          cnt_q[i]  <= '0;
          ev_q[i]   <= 1'b0;
          eoff_q[i] <= '0;
        end
      end

      if (pop) begin
        addr_q      <= base_q[tgt] + ADDR_W'(cnt_q[tgt]);
        wdata_q     <= head[DATA_W-1:0];
        cnt_q[tgt]  <= cnt_q[tgt] + 1'b1;
        if (at_last) begin
          act_q[tgt] <= 1'b0;
          cur_q      <= ~tgt;
        end
        if (head_bad && !ev_q[tgt]) begin
          ev_q[tgt]   <= 1'b1;
          eoff_q[tgt] <= cnt_q[tgt];
        end
      end

      if (ovf && busy && !ev_q[tgt]) begin
        ev_q[tgt]   <= 1'b1;
        eoff_q[tgt] <= ovf_ofs;
      end
    end
  end

  assign mem_we      = we_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign act_a       = act_q[0];
  assign act_b       = act_q[1];
  assign err_valid_a = ev_q[0];
  assign err_valid_b = ev_q[1];
  assign err_off_a   = eoff_q[0];
  assign err_off_b   = eoff_q[1];
  assign ovf_irq     = irq_q;
  assign ovf_status  = ovst_q;
endmodule

// File: rtl/rxdma_pingpong_chk.sv
module rxdma_pingpong_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_reset,
  input logic             load_a,
  input logic             load_b,
  input logic             mem_we,
  input logic             act_a,
  input logic             act_b,
  input logic             err_valid_a,
  input logic             err_valid_b,
  input logic [LEN_W-1:0] err_off_a,
  input logic [LEN_W-1:0] err_off_b,
  input logic             ovf_irq,
  input logic             ovf_status
);
  AST_WE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R2

  AST_WRITE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(act_a || act_b)); // R4

  AST_ACT_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_a && !load_a) |=> !act_a); // R3

  AST_ERR_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid_a && !dma_reset && !(load_a && !act_a)) |=> (err_valid_a && $stable(err_off_a))); // R5

  AST_ERR_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid_b && !dma_reset && !(load_b && !act_b)) |=> (err_valid_b && $stable(err_off_b))); // R5

  AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_status); // R6

  AST_DMA_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_reset |=> (!act_a && !act_b && !err_valid_a && !err_valid_b && !ovf_status && !mem_we)); // R9
endmodule

bind rxdma_pingpong rxdma_pingpong_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/rxdma_pingpong_test.sv
module rxdma_pingpong_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0;
  logic       load_a = 1'b0, load_b = 1'b0;
  logic [15:0] base_a = '0, base_b = '0;
  logic [7:0] len_a = '0, len_b = '0;
  logic       mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       act_a, act_b, err_valid_a, err_valid_b, ovf_irq, ovf_status;
  logic [7:0] err_off_a, err_off_b;

  int checks = 0, errors = 0;
  int wn = 0, irqs = 0;
  int log_addr [64];
  int log_data [64];

  rxdma_pingpong uut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && mem_we && wn < 64) begin
      log_addr[wn] = mem_addr;
      log_data[wn] = mem_wdata;
      wn = wn + 1;
    end
    if (rst_n && ovf_irq) irqs = irqs + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_dma();
    @(negedge clk) dma_reset = 1'b1;
    @(negedge clk) dma_reset = 1'b0;
    idle(1);
    wn = 0;
    irqs = 0;
  endtask

  task automatic arm(input bit which_b, input int base, input int len);
    @(negedge clk);
    if (which_b) begin load_b = 1'b1; base_b = 16'(base); len_b = 8'(len); end
    else begin load_a = 1'b1; base_a = 16'(base); len_a = 8'(len); end
    @(negedge clk);
    load_a = 1'b0;
    load_b = 1'b0;
  endtask

  task automatic send(input int d, input bit pe, input bit fe, input int gap);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'(d); rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    idle(gap);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 act_a", act_a, 0);
    check("R1 act_b", act_b, 0);
    check("R1 err_valid", err_valid_a | err_valid_b, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 ovf", ovf_irq | ovf_status, 0);
    rst_n = 1'b1;
    idle(2);

    for (int len = 1; len <= 4; len++) begin
      for (int e = 0; e < len; e++) begin
        int eb;
        eb = (e + 1) % len;
        clear_dma();
        arm(0, 'h40, len);
        arm(1, 'h80, len);
        for (int k = 0; k < 2 * len; k++) begin
          bit pe, fe;
          pe = (k == e) || (k == len + eb);
          fe = (k == len - 1) || (k == 2 * len - 1);
          send((k * 7 + len * 16 + e) & 8'hFF, pe, fe, 2);
        end
        idle(10);
        check("R2 write count", wn, 2 * len);
        for (int k = 0; k < 2 * len; k++) begin
          check("R2 addr", log_addr[k], (k < len) ? 'h40 + k : 'h80 + k - len);
          check("R2 data", log_data[k], (k * 7 + len * 16 + e) & 8'hFF);
        end
        check("R3 act_a done", act_a, 0);
        check("R3 act_b done", act_b, 0);
        check("R5 err_valid_a", err_valid_a, 1);
        check("R5 err_off_a first", err_off_a, e);
        check("R5 err_valid_b", err_valid_b, 1);
        check("R5 err_off_b first", err_off_b, eb);
      end
    end

    clear_dma();
    for (int k = 0; k < 4; k++) send('h10 + k, 0, 0, 1);
    idle(4);
    check("R4 held while idle", wn, 0);
    check("R6 no overrun yet", ovf_status, 0);
    send('h55, 0, 0, 3);
    check("R6 irq pulse", irqs, 1);
    check("R6 status sticky", ovf_status, 1);
    check("R7 no offset without buffer", err_valid_a | err_valid_b, 0);
    arm(0, 'h120, 6);
    idle(12);
    check("R4 queued count", wn, 4);
    for (int k = 0; k < 4; k++) begin
      check("R4 queued addr", log_addr[k], 'h120 + k);
      check("R4 queued data", log_data[k], 'h10 + k);
    end
    check("R8 load cleared err", err_valid_a, 0);
    check("R3 A still active", act_a, 1);
    arm(0, 'h200, 9);
    send('h61, 0, 0, 3);
    send('h62, 0, 0, 3);
    check("R8 active load ignored count", wn, 6);
    check("R8 active load ignored addr", log_addr[5], 'h125);
    check("R8 active load ignored len", act_a, 0);
    check("R6 status holds", ovf_status, 1);

    clear_dma();
    arm(0, 'h10, 2);
    send('h01, 1, 0, 2);
    send('h02, 0, 0, 4);
    check("R5 err set", err_valid_a, 1);
    check("R5 err off", err_off_a, 0);
    arm(0, 'h10, 2);
    check("R8 reload clears valid", err_valid_a, 0);
    check("R8 reload clears off", err_off_a, 0);
    arm(1, 'h30, 0);
    check("R10 zero length ignored", act_b, 0);

    clear_dma();
    arm(0, 'h100, 3);
    arm(1, 'h180, 2);
    for (int k = 0; k < 7; k++) send('h20 + k, 0, 0, 2);
    idle(6);
    check("R3 pingpong count", wn, 5);
    check("R3 A then B addr", log_addr[3], 'h180);
    check("R3 B data", log_data[4], 'h24);
    arm(0, 'h300, 4);
    idle(8);
    check("R4 resume count", wn, 7);
    check("R4 resume addr", log_addr[5], 'h300);
    check("R4 resume data", log_data[6], 'h26);
    check("R3 A active again", act_a, 1);

    clear_dma();
    arm(0, 'h0, 40);
    idle(2);
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      rx_valid = 1'b1; rx_data = 8'('hA0 + k);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    idle(20);
    begin
      int lost;
      lost = 16;
      for (int k = 15; k >= 0; k--) if (k >= wn || log_data[k] != 'hA0 + k) lost = k;
      check("R2 first lost index", lost, 8);
      check("R6 overrun status", ovf_status, 1);
      check("R6 irq seen", (irqs > 0) ? 1 : 0, 1);
      check("R7 err valid", err_valid_a, 1);
      check("R7 shifted offset", err_off_a, lost + 4);
      send('hEE, 1, 1, 4);
      check("R5 later error ignored", err_off_a, lost + 4);
    end

    @(negedge clk) dma_reset = 1'b1;
    @(negedge clk) dma_reset = 1'b0;
    check("R9 act cleared", act_a | act_b, 0);
    check("R9 err cleared", err_valid_a | err_valid_b, 0);
    check("R9 ovf cleared", ovf_status, 0);
    for (int k = 0; k < 3; k++) send('h70 + k, 0, 0, 1);
    clear_dma();
    arm(0, 'h400, 4);
    idle(10);
    check("R9 queue flushed", wn, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule